// File: doc/BRIEF.md
# Transmit Frame Padder and Check-Sequence Appender

This stage sits in an Ethernet transmit path, between whatever produces outgoing frames and the line encoder. Frames arrive as a byte stream with a first-byte marker (`in_sof`) and a last-byte marker (`in_eof`). Three controls go with each frame: a global pad enable, a global check-sequence disable, and a per-frame request to add the check sequence. The stage copies the payload through. If padding is enabled and the frame is short, it adds zero bytes. It then appends a 32-bit CRC frame check sequence.

Padding takes precedence over both check-sequence controls. A padded frame always ends with a CRC, and that CRC covers the pad bytes as well as the payload. While the stage emits pad or CRC bytes it holds off the source. The output uses a valid/ready handshake and marks the last byte of each frame.

Top module: `txpad_fcs`

## Requirements
- R1: With padding enabled, a payload shorter than MIN_FRAME-4 bytes (60 with the default MIN_FRAME of 64) is extended, so the emitted frame, CRC included, is exactly MIN_FRAME bytes long.
- R2: Pad bytes are 0x00. A payload of MIN_FRAME-4 bytes or more gets no pad bytes.
- R3: The check sequence is reflected CRC-32 (polynomial 0x04C11DB7, register preset to all ones, result complemented). It is computed over the payload and any pad bytes. It is sent as the final four bytes of the frame, after the pad, least significant byte first. For the ASCII payload "123456789" the four bytes are 26 39 F4 CB.
- R4: With padding enabled, the CRC is appended whatever the values of `cfg_fcs_off` and `frm_fcs_req`.
- R5: With padding disabled, no pad bytes are added. The CRC is appended only when `cfg_fcs_off` is 0 or `frm_fcs_req` is 1. Otherwise `out_eof` is raised on the last payload byte.
- R6: `cfg_pad_en`, `cfg_fcs_off` and `frm_fcs_req` are sampled with the byte that carries `in_sof`. Later changes have no effect on that frame.
- R7: `in_ready` is 0 from the cycle after the last payload byte is accepted until the last pad or CRC byte has been loaded for output, whenever such bytes follow.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_eof` hold their values. Under any pattern of stalls, every byte is delivered exactly once and in order.
- R9: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Stage accepts an input byte |
| in_data | input | 8 | Input payload byte |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last payload byte of a frame |
| cfg_pad_en | input | 1 | Global pad enable |
| cfg_fcs_off | input | 1 | Global check-sequence disable |
| frm_fcs_req | input | 1 | Per-frame request to append the check sequence |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts the output byte |
| out_data | output | 8 | Output byte |
| out_eof | output | 1 | Marks the last byte of the emitted frame |

## Verification
The bench uses the default MIN_FRAME of 64. This puts the pad boundary at a 60-byte payload, so payloads of 1, 59, 60 and 61 bytes probe both sides of it directly. Random payload lengths up to 100 bytes cross the boundary many times. At this setting every padded frame also runs the length counter up to saturation. One fixed 9-byte vector, plus a check of the CRC residue over each received frame, tests the check sequence without relying on the bench's own CRC model.

// File: rtl/txpad_pkg.sv
package txpad_pkg;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam int          FCS_BYTES     = 4;

  typedef enum logic [1:0] {
    ST_PASS = 2'd0,
    ST_PAD  = 2'd1,
    ST_FCS  = 2'd2
  } tx_state_e;

  // one byte through the reflected CRC-32 register, LSB of the byte first
  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/txpad_crc.sv
module txpad_crc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc
);
  import txpad_pkg::*;

  logic [31:0] crc_q, crc_base, crc_d;

  always_comb begin
    crc_base = init ? 32'hFFFF_FFFF : crc_q;
    crc_d    = crc32_byte(crc_base, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  crc_q <= 32'hFFFF_FFFF;
    else if (en) crc_q <= crc_d;
  end

  assign crc = crc_q;

endmodule

// File: rtl/txpad_cnt.sv
module txpad_cnt #(
  parameter int LIMIT = 60,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nx
);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q, base;

  always_comb begin
    base   = clr ? '0 : cnt_q;
    cnt_nx = (en && base != LIM) ? base + 1'b1 : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (en || clr) cnt_q <= cnt_nx;
  end

  assign cnt = cnt_q;

  // saturating length count never passes the pad target
  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);

endmodule

// File: rtl/txpad_fcs.sv
module txpad_fcs #(
  parameter int MIN_FRAME = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic       cfg_pad_en,
  input  logic       cfg_fcs_off,
  input  logic       frm_fcs_req,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_eof
);
  import txpad_pkg::*;

  localparam int PAYLOAD_MIN = MIN_FRAME - FCS_BYTES;
  localparam int CNT_W       = $clog2(PAYLOAD_MIN + 1);
  localparam int IDX_W       = $clog2(FCS_BYTES);
  localparam logic [CNT_W-1:0] PAY_LIM  = CNT_W'(PAYLOAD_MIN);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FCS_BYTES - 1);

  tx_state_e        state_q, state_d;
  logic             out_valid_q, out_valid_d;
  logic [7:0]       out_data_q, out_data_d;
  logic             out_eof_q, out_eof_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             pad_q, fcs_q;
  logic             ld, take, pad_e, fcs_e;
  logic             crc_en, crc_init, cnt_en, cnt_clr;
  logic [7:0]       crc_din;
  logic [31:0]      crc, crc_fin;
  logic [CNT_W-1:0] cnt, cnt_nx;

  // output register free or being drained this cycle
  assign ld       = !out_valid_q || out_ready;
  assign in_ready = (state_q == ST_PASS) && ld;
  assign take     = in_valid && in_ready;
  assign pad_e    = in_sof ? cfg_pad_en : pad_q;
  assign fcs_e    = in_sof ? (cfg_pad_en | ~cfg_fcs_off | frm_fcs_req) : fcs_q;
  assign crc_fin  = ~crc;

  txpad_crc u_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .init (crc_init),
    .en   (crc_en),
    .din  (crc_din),
    .crc  (crc)
  );

  txpad_cnt #(.LIMIT(PAYLOAD_MIN)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .en    (cnt_en),
    .cnt   (cnt),
    .cnt_nx(cnt_nx)
  );

  always_comb begin
    state_d     = state_q;
    out_valid_d = out_valid_q && !out_ready;
    out_data_d  = out_data_q;
    out_eof_d   = out_eof_q;
    idx_d       = idx_q;
    crc_en      = 1'b0;
    crc_init    = 1'b0;
    crc_din     = in_data;
    cnt_en      = 1'b0;
    cnt_clr     = 1'b0;
    unique case (state_q)
      ST_PASS: begin
        if (take) begin
          out_valid_d = 1'b1;
          out_data_d  = in_data;
          out_eof_d   = 1'b0;
          crc_en      = 1'b1;
          crc_init    = in_sof;
          cnt_en      = 1'b1;
          cnt_clr     = in_sof;
          if (in_eof) begin
            if (pad_e && cnt_nx < PAY_LIM) begin
              state_d = ST_PAD;
            end else if (fcs_e) begin
              state_d = ST_FCS;
              idx_d   = '0;
            end else begin
              out_eof_d = 1'b1;
            end
          end
        end
      end
      ST_PAD: begin
        if (ld) begin
          out_valid_d = 1'b1;
          out_data_d  = 8'h00;
          out_eof_d   = 1'b0;
          crc_en      = 1'b1;
          crc_din     = 8'h00;
          cnt_en      = 1'b1;
          if (cnt_nx == PAY_LIM) begin
            state_d = ST_FCS;
            idx_d   = '0;
          end
        end
      end
      ST_FCS: begin
        if (ld) begin
          out_valid_d = 1'b1;
          out_data_d  = crc_fin[{idx_q, 3'b000} +: 8];
          out_eof_d   = (idx_q == IDX_LAST);
          idx_d       = idx_q + 1'b1;
          if (idx_q == IDX_LAST) state_d = ST_PASS;
        end
      end
      default: state_d = ST_PASS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_PASS;
      out_valid_q <= 1'b0;
      out_data_q  <= 8'h00;
      out_eof_q   <= 1'b0;
      idx_q       <= '0;
      pad_q       <= 1'b0;
      fcs_q       <= 1'b0;
    end else begin
      state_q     <= state_d;
      out_valid_q <= out_valid_d;
      idx_q       <= idx_d;
      if (ld) begin
        out_data_q <= out_data_d;
        out_eof_q  <= out_eof_d;
      end
      if (take && in_sof) begin
        pad_q <= pad_e;
        fcs_q <= fcs_e;
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
  assign out_eof   = out_eof_q;

  // stalled output holds its byte
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_q && !out_ready) |=> (out_valid_q && $stable(out_data_q) && $stable(out_eof_q)));

  // pad bytes leave as zero
  assert_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAD && ld) |=> (out_valid_q && out_data_q == 8'h00));

  // a padded frame reaches the minimum length before its CRC starts
  assert_pad_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FCS) |-> (!pad_q || cnt == PAY_LIM));

  // last CRC byte closes the frame
  assert_eof_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FCS && ld && idx_q == IDX_LAST) |=> (out_eof_q && state_q == ST_PASS));

  // source is held off while pad or CRC bytes are produced
  assert_stall_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_PASS) |=> ($past(in_ready) == 1'b0));

endmodule

// File: tb/tb_txpad_fcs.sv
module tb_txpad_fcs;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, in_sof, in_eof;
  logic [7:0] in_data;
  logic       cfg_pad_en, cfg_fcs_off, frm_fcs_req;
  logic       out_valid, out_ready, out_eof;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;
  int rx_frames = 0;
  logic [7:0] pay_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] cur_q[$];
  logic [7:0] rx_last[$];

  always #5 clk = ~clk;

  txpad_fcs dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof),
    .cfg_pad_en(cfg_pad_en), .cfg_fcs_off(cfg_fcs_off), .frm_fcs_req(frm_fcs_req),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_eof(out_eof)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reflected CRC-32 register over a queue, no final inversion
  function automatic logic [31:0] crc_reg(input logic [7:0] q[$]);
    logic [31:0] r = 32'hFFFF_FFFF;
    foreach (q[i]) begin
      for (int b = 0; b < 8; b++) begin
        logic fb = r[0] ^ q[i][b];
        r = r >> 1;
        if (fb) r = r ^ 32'hEDB88320;
      end
    end
    return r;
  endfunction

  function automatic void build_exp(input bit pad, input bit foff, input bit freq);
    logic [31:0] f;
    exp_q = pay_q;
    if (pad) while (exp_q.size() < 60) exp_q.push_back(8'h00);
    if (pad || !foff || freq) begin
      f = ~crc_reg(exp_q);
      for (int k = 0; k < 4; k++) exp_q.push_back(f[8*k +: 8]);
    end
  endfunction

  // sink: random backpressure, capture, stall check
  initial begin
    bit         prev_stall = 0;
    logic [7:0] prev_data = 8'h00;
    logic       prev_eof = 1'b0;
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      out_ready = ($urandom % 4) != 0;
      #1;
      if (rst_n) begin
        if (prev_stall)
          chk(out_valid && out_data == prev_data && out_eof == prev_eof, "R8", "stalled byte held",
              {out_valid, out_data}, {1'b1, prev_data});
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
        prev_eof   = out_eof;
        if (out_valid && out_ready) begin
          cur_q.push_back(out_data);
          if (out_eof) begin
            rx_last = cur_q;
            cur_q.delete();
            rx_frames++;
          end
        end
      end
    end
  end

  task automatic send_frame(input bit pad, input bit foff, input bit freq, input string req);
    int n = pay_q.size();
    int i = 0;
    int tgt = rx_frames + 1;
    build_exp(pad, foff, freq);
    while (i < n) begin
      @(negedge clk);
      if ($urandom % 5 == 0) begin
        in_valid = 1'b0;
        in_sof = $urandom;
      end else begin
        in_valid = 1'b1;
        in_data  = pay_q[i];
        in_sof   = (i == 0);
        in_eof   = (i == n - 1);
        if (i == 0) begin
          cfg_pad_en = pad; cfg_fcs_off = foff; frm_fcs_req = freq;
        end else begin
          // R6: mid-frame control changes must be ignored
          cfg_pad_en = $urandom; cfg_fcs_off = $urandom; frm_fcs_req = $urandom;
        end
        #1;
        if (in_ready) i++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    #2;
    if (exp_q.size() > n)
      chk(in_ready == 1'b0, "R7", "in_ready during pad/CRC", in_ready, 0);
    wait (rx_frames == tgt);
    begin
      bit ok = (rx_last.size() == exp_q.size());
      int bad = -1;
      if (ok) foreach (exp_q[k]) if (bad < 0 && rx_last[k] !== exp_q[k]) bad = k;
      if (!ok)
        chk(0, req, "frame length", rx_last.size(), exp_q.size());
      else if (bad >= 0)
        chk(0, req, $sformatf("byte %0d", bad), rx_last[bad], exp_q[bad]);
      else
        chk(1, req, "frame", 0, 0);
    end
    if (exp_q.size() != n)
      chk(crc_reg(rx_last) == 32'hDEBB20E3, "R3", "CRC residue", crc_reg(rx_last), 32'hDEBB20E3);
  endtask

  task automatic fill(input int n, input bit zero);
    pay_q.delete();
    for (int k = 0; k < n; k++) pay_q.push_back(zero ? 8'h00 : 8'($urandom));
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00;
    cfg_pad_en = 1'b0; cfg_fcs_off = 1'b0; frm_fcs_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid in reset", out_valid, 0);
    chk(in_ready == 1'b1, "R9", "in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);

    fill(1, 0);  send_frame(1, 0, 1, "R1");
    fill(59, 0); send_frame(1, 0, 0, "R1");
    fill(60, 0); send_frame(1, 0, 0, "R2");
    fill(61, 0); send_frame(1, 1, 0, "R2");
    fill(10, 1); send_frame(1, 1, 0, "R4");
    fill(75, 0); send_frame(1, 1, 0, "R4");
    fill(20, 0); send_frame(0, 1, 0, "R5");
    fill(20, 0); send_frame(0, 1, 1, "R5");
    fill(20, 0); send_frame(0, 0, 0, "R5");

    pay_q.delete();
    for (int k = 0; k < 9; k++) pay_q.push_back(8'h31 + 8'(k));
    send_frame(0, 0, 0, "R3");
    chk({rx_last[12], rx_last[11], rx_last[10], rx_last[9]} == 32'hCBF43926, "R3", "known vector",
        {rx_last[12], rx_last[11], rx_last[10], rx_last[9]}, 32'hCBF43926);

    for (int f = 0; f < 40; f++) begin
      fill(1 + ($urandom % 100), 0);
      send_frame($urandom, $urandom, $urandom, "R6");
    end

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule